// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address to a physical page address using a small bank of block translation entries. It keeps one bank for instruction fetches and a separate bank for data accesses. Each entry is a pair of 32-bit words.

The upper word of an entry holds three things: the effective block base, a length field that widens the block, and two privilege-valid bits. The lower word holds the physical block base and a two-bit protection field. On each request the block checks every entry of the selected bank in parallel. The entry with the lowest index that matches supplies the physical page address and an access-rights code. When no entry matches, the block raises a miss flag.

Software-visible register access sits outside this block. The entry words are loaded through a plain write port. The lookup logic is purely combinational, and the result is registered, so it appears one cycle after the request.

Top module: `bat_xlate`

## Requirements
- R1: While reset is asserted and right after it, `rsp_valid`, `rsp_miss`, `rsp_pa` and `rsp_prot` are all zero. All entry words reset to zero, so every lookup made before any write misses.
- R2: A request presented with `req_valid` high at a rising edge produces `rsp_valid` high after that edge, holding the result for that request. A cycle without a request produces `rsp_valid` low after the edge, and the result outputs hold their previous values.
- R3: An entry may match only if its privilege-valid bit for the access level is set. Upper-word bit 0 enables the entry for user accesses (`req_user`=1). Upper-word bit 1 enables it for supervisor accesses (`req_user`=0).
- R4: The compare mask is 0xFFFE0000 with the bits of upper-word field 12:2, shifted left by 15, cleared from it. An entry matches when the effective address ANDed with this mask equals upper-word bits 31:17, with bits 16:0 taken as zero.
- R5: On a hit, `rsp_pa` equals (lower word AND mask) OR (effective address AND NOT mask), with bits 11:0 forced to zero.
- R6: When `req_ifetch`=1 the lookup searches only the instruction bank. When `req_ifetch`=0 it searches only the data bank.
- R7: When several entries of the searched bank match, the entry with the lowest index supplies the result.
- R8: On a hit, `rsp_prot` is derived from lower-word bits 1:0. A value of 00 gives 0 (no access). A value of 10 gives 2 (read/write). A value of 01 or 11 gives 1 (read-only). `rsp_prot` never takes the value 3.
- R9: When no entry matches, `rsp_miss` is 1 and both `rsp_pa` and `rsp_prot` are 0. When an entry matches, `rsp_miss` is 0.
- R10: A write with `wr_en` high updates one word, selected by `wr_ifetch` (1 = instruction bank), `wr_idx` and `wr_upper` (1 = upper word). A request in the same cycle as the write still sees the old contents. Requests from the following cycle onward see the new value. The other bank is not affected by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry word write strobe |
| wr_ifetch | input | 1 | Write target bank: 1 instruction, 0 data |
| wr_idx | input | IDX_W | Entry index to write |
| wr_upper | input | 1 | 1 writes the upper word, 0 the lower word |
| wr_data | input | 32 | Word to store |
| req_valid | input | 1 | Lookup request |
| req_ifetch | input | 1 | Request is an instruction fetch |
| req_user | input | 1 | Request runs at user privilege |
| req_ea | input | 32 | Effective address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_miss | output | 1 | No entry matched |
| rsp_pa | output | 32 | Physical page address |
| rsp_prot | output | 2 | 0 none, 1 read-only, 2 read/write |

## Verification
The observable state of this block is limited to the stored entry words and the one result register. A wrongly stored word, or a write that lands in the wrong bank, stays invisible until a lookup in that bank touches the region the entry covers. At that point it shows up one cycle later, either as a wrong page address or protection code, or as an unexpected hit or miss. For this reason the bench mixes random writes with random lookups whose addresses are aimed at the programmed bases. A faulty priority chain only shows when entries overlap, so directed cases place overlapping blocks of different sizes in the same bank.

// File: rtl/bat_pkg.sv
package bat_pkg;
  localparam int WORD_W    = 32;
  localparam int PAGE_BITS = 12;
  localparam int BASE_LSB  = 17;
  localparam int LEN_LSB   = 2;
  localparam int LEN_MSB   = 12;
  localparam int LEN_SHIFT = BASE_LSB - LEN_LSB;

  typedef enum logic [1:0] {
    PROT_NONE = 2'd0,
    PROT_RO   = 2'd1,
    PROT_RW   = 2'd2
  } prot_e;

  typedef struct packed {
    logic              hit;
    logic [WORD_W-1:0] pa;
    prot_e             prot;
  } bat_result_t;
endpackage

// File: rtl/bat_regfile.sv
module bat_regfile
  import bat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic                                wr_ifetch,
  input  logic [IDX_W-1:0]                    wr_idx,
  input  logic                                wr_upper,
  input  logic [WORD_W-1:0]                   wr_data,
  input  logic                                rd_ifetch,
  output logic [NUM_ENTRIES-1:0][WORD_W-1:0]  upper_o,
  output logic [NUM_ENTRIES-1:0][WORD_W-1:0]  lower_o
);
  localparam int NUM_SETS = 2;

  logic [NUM_SETS-1:0][NUM_ENTRIES-1:0][WORD_W-1:0] upper_q, lower_q;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      logic sel;
      assign sel = wr_en && (wr_ifetch == s[0]) && (wr_idx == e[IDX_W-1:0]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          upper_q[s][e] <= '0;
          lower_q[s][e] <= '0;
        end else if (sel) begin
          if (wr_upper) upper_q[s][e] <= wr_data;
          else          lower_q[s][e] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    upper_o = upper_q[rd_ifetch];
    lower_o = lower_q[rd_ifetch];
  end
endmodule

// File: rtl/bat_entry_match.sv
module bat_entry_match
  import bat_pkg::*;
(
  input  logic [WORD_W-1:0] upper,
  input  logic [WORD_W-1:0] lower,
  input  logic [WORD_W-1:0] ea,
  input  logic              user,
  output bat_result_t       res
);
  logic              usable;
  logic [WORD_W-1:0] base_field;
  logic [WORD_W-1:0] len_field;
  logic [WORD_W-1:0] mask;
  logic [WORD_W-1:0] merged;

  always_comb begin
    usable     = user ? upper[0] : upper[1];
    base_field = {upper[WORD_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
    len_field  = {{(WORD_W-LEN_MSB-1){1'b0}}, upper[LEN_MSB:LEN_LSB], {LEN_LSB{1'b0}}};
    mask       = {{(WORD_W-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}} & ~(len_field << LEN_SHIFT);
    merged     = (lower & mask) | (ea & ~mask);
    res.hit    = usable && ((ea & mask) == base_field);
    res.pa     = {merged[WORD_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    unique case (lower[1:0])
      2'b00:   res.prot = PROT_NONE;
      2'b10:   res.prot = PROT_RW;
      default: res.prot = PROT_RO;
    endcase
  end
endmodule

// File: rtl/bat_first_hit.sv
module bat_first_hit
  import bat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  bat_result_t [NUM_ENTRIES-1:0] cand,
  output bat_result_t                   win
);
  always_comb begin
    win = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (cand[i].hit) win = cand[i];
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_ifetch,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_upper,
  input  logic [31:0]       wr_data,
  input  logic              req_valid,
  input  logic              req_ifetch,
  input  logic              req_user,
  input  logic [31:0]       req_ea,
  output logic              rsp_valid,
  output logic              rsp_miss,
  output logic [31:0]       rsp_pa,
  output logic [1:0]        rsp_prot
);
  logic [NUM_ENTRIES-1:0][WORD_W-1:0] upper_w, lower_w;
  bat_result_t [NUM_ENTRIES-1:0]      cand;
  bat_result_t                        win;

  logic              valid_q, valid_d;
  logic              miss_q, miss_d;
  logic [WORD_W-1:0] pa_q, pa_d;
  logic [1:0]        prot_q, prot_d;

  bat_regfile #(.NUM_ENTRIES(NUM_ENTRIES)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_ifetch (wr_ifetch),
    .wr_idx    (wr_idx),
    .wr_upper  (wr_upper),
    .wr_data   (wr_data),
    .rd_ifetch (req_ifetch),
    .upper_o   (upper_w),
    .lower_o   (lower_w)
  );

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_match
    bat_entry_match i_match (
      .upper (upper_w[e]),
      .lower (lower_w[e]),
      .ea    (req_ea),
      .user  (req_user),
      .res   (cand[e])
    );
  end

  bat_first_hit #(.NUM_ENTRIES(NUM_ENTRIES)) i_pick (
    .cand (cand),
    .win  (win)
  );

  always_comb begin
    valid_d = req_valid;
    miss_d  = miss_q;
    pa_d    = pa_q;
    prot_d  = prot_q;
    if (req_valid) begin
      miss_d = !win.hit;
      pa_d   = win.hit ? win.pa : '0;
      prot_d = win.hit ? win.prot : PROT_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      miss_q  <= 1'b0;
      pa_q    <= '0;
      prot_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (req_valid) begin
        miss_q <= miss_d;
        pa_q   <= pa_d;
        prot_q <= prot_d;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_miss  = miss_q;
  assign rsp_pa    = pa_q;
  assign rsp_prot  = prot_q;
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_ea,
  input logic        rsp_valid,
  input logic        rsp_miss,
  input logic [31:0] rsp_pa,
  input logic [1:0]  rsp_prot
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> $stable(rsp_pa) && $stable(rsp_miss)); // R2
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_miss) |-> (rsp_pa == 32'd0 && rsp_prot == 2'd0)); // R9
  AST_PAGE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> (rsp_pa[11:0] == 12'd0)); // R5
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid ##1 (rsp_valid && !rsp_miss)) |-> (rsp_pa[16:12] == $past(req_ea[16:12]))); // R5
  AST_PROT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) rsp_prot != 2'd3); // R8
endmodule

bind bat_xlate bat_xlate_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ea    (req_ea),
  .rsp_valid (rsp_valid),
  .rsp_miss  (rsp_miss),
  .rsp_pa    (rsp_pa),
  .rsp_prot  (rsp_prot)
);

// File: tb/test_bat_xlate.sv
module test_bat_xlate;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_ifetch = 1'b0, wr_upper = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic req_valid = 1'b0, req_ifetch = 1'b0, req_user = 1'b0;
  logic [31:0] req_ea = '0;
  logic rsp_valid, rsp_miss;
  logic [31:0] rsp_pa;
  logic [1:0] rsp_prot;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  // reference state
  logic [31:0] m_up [2][N];
  logic [31:0] m_lo [2][N];
  logic e_valid = 1'b0, e_miss = 1'b0;
  logic [31:0] e_pa = '0;
  logic [1:0] e_prot = '0;
  string e_tag = "R1";

  always #4 clk = ~clk;

  bat_xlate #(.NUM_ENTRIES(N)) i_bat_xlate (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_ifetch(wr_ifetch), .wr_idx(wr_idx), .wr_upper(wr_upper), .wr_data(wr_data),
    .req_valid(req_valid), .req_ifetch(req_ifetch), .req_user(req_user), .req_ea(req_ea),
    .rsp_valid(rsp_valid), .rsp_miss(rsp_miss), .rsp_pa(rsp_pa), .rsp_prot(rsp_prot)
  );

  // behavioural model, evaluated at every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < N; e++) begin m_up[s][e] = 0; m_lo[s][e] = 0; end
      e_valid = 0; e_miss = 0; e_pa = 0; e_prot = 0;
    end else begin
      e_valid = req_valid;
      if (req_valid) begin
        int set;
        bit found;
        set = req_ifetch ? 1 : 0;
        found = 0;
        e_miss = 1; e_pa = 0; e_prot = 0;
        for (int e = 0; e < N; e++) begin
          logic [31:0] u, l, m;
          u = m_up[set][e]; l = m_lo[set][e];
          m = 32'hFFFE_0000 & ~((u & 32'h0000_1FFC) << 15);
          if (!found && (req_user ? u[0] : u[1]) && ((req_ea & m) == (u & 32'hFFFE_0000))) begin
            found = 1;
            e_miss = 0;
            e_pa = ((l & m) | (req_ea & ~m)) & 32'hFFFF_F000;
            case (l[1:0])
              2'b00: e_prot = 0;
              2'b10: e_prot = 2;
              default: e_prot = 1;
            endcase
          end
        end
        e_tag = cur_tag;
      end
      if (wr_en) begin
        if (wr_upper) m_up[wr_ifetch ? 1 : 0][wr_idx] = wr_data;
        else          m_lo[wr_ifetch ? 1 : 0][wr_idx] = wr_data;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rsp_valid !== e_valid) begin
        errors++;
        $display("FAIL R2 (%s): rsp_valid=%0b expected %0b", e_tag, rsp_valid, e_valid);
      end else if (e_valid && (rsp_miss !== e_miss || rsp_pa !== e_pa || rsp_prot !== e_prot)) begin
        errors++;
        $display("FAIL %s: miss/pa/prot=%0b/%h/%0d expected %0b/%h/%0d",
                 e_tag, rsp_miss, rsp_pa, rsp_prot, e_miss, e_pa, e_prot);
      end
    end
  end

  task automatic wr(input bit iset, input int idx, input bit up, input logic [31:0] d);
    wr_en = 1; wr_ifetch = iset; wr_idx = idx[IW-1:0]; wr_upper = up; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rq(input bit ifetch, input bit user, input logic [31:0] ea);
    req_valid = 1; req_ifetch = ifetch; req_user = user; req_ea = ea;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_miss !== 0 || rsp_pa !== 0 || rsp_prot !== 0) begin
      errors++;
      $display("FAIL R1: outputs in reset %b/%b/%h/%0d expected all zero", rsp_valid, rsp_miss, rsp_pa, rsp_prot);
    end
    rst_n = 1;
    @(negedge clk);
    cur_tag = "R1"; rq(0, 0, 32'h1000_0000); rq(1, 1, 32'h0000_0000);
    @(negedge clk);

    // R3: supervisor-only entry, read/write
    wr(0, 0, 1, 32'h1000_0002); wr(0, 0, 0, 32'h8000_0002);
    cur_tag = "R3"; rq(0, 1, 32'h1000_4567); rq(0, 0, 32'h1000_4567);
    wr(0, 0, 1, 32'h1000_0001);
    rq(0, 1, 32'h1001_F123); rq(0, 0, 32'h1001_F123);

    // R4/R5: 512 KiB block (length field 3)
    wr(0, 1, 1, 32'h2000_000F); wr(0, 1, 0, 32'h9000_0001);
    cur_tag = "R4"; rq(0, 0, 32'h2008_0000); rq(0, 1, 32'h2004_0000);
    cur_tag = "R5"; rq(0, 0, 32'h2007_1234); rq(0, 1, 32'h2006_5FFF);

    // R7: overlapping entries, lowest index wins
    wr(0, 2, 1, 32'h2000_0003); wr(0, 2, 0, 32'hC000_0002);
    wr(0, 3, 1, 32'h2000_1FFF); wr(0, 3, 0, 32'hE000_0003);
    cur_tag = "R7"; rq(0, 0, 32'h2001_0000); rq(0, 0, 32'h2010_0000); rq(0, 0, 32'h3FFF_FFFF);

    // R6/R8: instruction bank, no-access and read-only codes
    wr(1, 0, 1, 32'h1000_0003); wr(1, 0, 0, 32'hA000_0000);
    wr(1, 1, 1, 32'h4000_0003); wr(1, 1, 0, 32'h5000_0003);
    cur_tag = "R6"; rq(1, 1, 32'h1000_0ABC); rq(0, 1, 32'h1000_0ABC); rq(0, 0, 32'h4000_0000);
    cur_tag = "R8"; rq(1, 0, 32'h4001_2345); rq(1, 1, 32'h1000_2000);

    // R9: misses
    cur_tag = "R9"; rq(0, 0, 32'h7000_0000); rq(1, 0, 32'hFFFF_FFFF);

    // R10: write and request in the same cycle, then afterwards
    cur_tag = "R10";
    wr_en = 1; wr_ifetch = 0; wr_idx = 0; wr_upper = 0; wr_data = 32'h6000_0003;
    req_valid = 1; req_ifetch = 0; req_user = 1; req_ea = 32'h1000_0000;
    @(negedge clk);
    wr_en = 0;
    rq(0, 1, 32'h1000_0000); rq(1, 1, 32'h1000_0000);

    // random mix
    cur_tag = "R7";
    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom_range(0, 3);
      if (r == 0) begin
        logic [31:0] d;
        d = $urandom;
        wr($urandom_range(0, 1), $urandom_range(0, N - 1), $urandom_range(0, 1),
           {d[31:30], 14'd0, d[15:0]});
      end else begin
        logic [31:0] a;
        a = $urandom;
        rq($urandom_range(0, 1), $urandom_range(0, 1), {a[31:30], a[29:0] & 32'h000F_FFFF});
      end
      if ($urandom_range(0, 4) == 0) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule